// File: doc/BRIEF.md
# GPIO Pin Control Cell

This cell holds everything a single general-purpose pin needs: one 32-bit control word, the logic that turns that word into pad controls, and an interrupt detector. Software writes the control word to choose a pull resistor, a push-pull or open-drain driver, the driver enable, the driven level and a function selector. The function selector either keeps the pin as plain GPIO or hands the pad to one of three alternate-function sources.

The pad input passes through a two-flop synchronizer. The synchronized level is readable in the control word. It also feeds a detector that raises an event toward an interrupt aggregator, either while a chosen level is present or for one cycle on a chosen edge. The aggregator itself and the analog pad are outside this block.

Top module: `gpio_pin_cell`

## Requirements
- R1: After reset the control word reads 0x0000_0440: the input-mode flag (bit 10) is set, the detect field (bits [6:4]) is 100, and all other bits are 0. While reset holds, pad_oe, pad_pu, pad_pd and evt are 0.
- R2: Pull field bits [1:0] drive the pull outputs: 01 gives pad_pu=1, 10 gives pad_pd=1, and 00 or 11 gives neither. The two pull outputs are never high together.
- R3: With function select bits [13:12] = 0 and open-drain bit 8 clear, pad_out follows the level bit 16 and pad_oe follows the driver-enable bit 9.
- R4: With bit 8 set, pad_out is 0, and pad_oe equals the selected source's enable AND NOT the selected source's level, so a high level releases the pad.
- R5: Function select values 1, 2 and 3 route alt_out[n-1] and alt_oe[n-1] to the pad in place of bits 16 and 9. The open-drain rule of R4 still applies.
- R6: Bit 24 reads the pad input after two register stages: a change on pad_in before clock edge k is visible from edge k+1 onward. Bit 24 and every bit outside {1:0, 7:4, 10:8, 13:12, 16} ignore writes; the unassigned bits read 0. The writable mask is 0x0001_37F3.
- R7: Detect code 000 raises evt in every cycle in which bit 24 is 0. Code 001 raises evt in every cycle in which bit 24 is 1. Edge-enable bit 7 has no effect on these two codes.
- R8: With bit 7 set, codes 101, 110 and 111 raise evt for exactly one cycle after the synchronized level rises, falls, or changes either way, respectively. That cycle is the one in which bit 24 first shows the new value. With bit 7 clear, these codes raise no event.
- R9: Detect codes 100, 010 and 011 never raise evt.
- R10: A write takes effect at the clock edge on which reg_wr is high. reg_rdata is combinational from the stored state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_wr | input | 1 | Control word write strobe |
| reg_wdata | input | 32 | Control word write data |
| reg_rdata | output | 32 | Control word read data, with the synchronized pin level in bit 24 |
| pad_in | input | 1 | Pad input level |
| pad_out | output | 1 | Pad output level |
| pad_oe | output | 1 | Pad output enable |
| pad_pu | output | 1 | Pull-up enable |
| pad_pd | output | 1 | Pull-down enable |
| alt_out | input | 3 | Output level from alternate functions 1..3 |
| alt_oe | input | 3 | Output enable from alternate functions 1..3 |
| evt | output | 1 | Interrupt event toward the aggregator |

## Verification
The assertions assume that pad_in may be asynchronous to clk, but that it is only observed through the synchronizer. They also assume that the control word changes only through the write strobe. The bench changes pad_in, alt_out, alt_oe and the write data only on falling clock edges, so every value is stable at the rising edge. Random writes cover all eight detect codes and all four function-select codes, including the unused ones. The input pattern alternates between held levels and rapid toggles, so both level events and back-to-back edge pulses occur.

// File: rtl/gpio_cell_pkg.sv
package gpio_cell_pkg;
  localparam int CTL_W       = 32;
  localparam int PULL_LSB    = 0;
  localparam int DET_LSB     = 4;
  localparam int EDGE_EN_BIT = 7;
  localparam int OD_BIT      = 8;
  localparam int DRV_EN_BIT  = 9;
  localparam int IN_MODE_BIT = 10;
  localparam int FSEL_LSB    = 12;
  localparam int LEVEL_BIT   = 16;
  localparam int PIN_BIT     = 24;

  localparam logic [CTL_W-1:0] CTL_WMASK = 32'h0001_37F3;
  localparam logic [CTL_W-1:0] CTL_RESET = 32'h0000_0440;

  localparam logic [2:0] DET_LOW  = 3'b000;
  localparam logic [2:0] DET_HIGH = 3'b001;
  localparam logic [2:0] DET_OFF  = 3'b100;
  localparam logic [2:0] DET_RISE = 3'b101;
  localparam logic [2:0] DET_FALL = 3'b110;
  localparam logic [2:0] DET_BOTH = 3'b111;

  // Returns {pull_down, pull_up}.
  function automatic logic [1:0] pull_decode(input logic [1:0] f);
    case (f)
      2'b01:   return 2'b01;
      2'b10:   return 2'b10;
      default: return 2'b00;
    endcase
  endfunction

  function automatic logic det_event(input logic [2:0] mode, input logic edge_en,
                                     input logic lvl, input logic prev);
    logic rise, fall;
    rise = lvl & ~prev;
    fall = ~lvl & prev;
    case (mode)
      DET_LOW:  return ~lvl;
      DET_HIGH: return lvl;
      DET_RISE: return edge_en & rise;
      DET_FALL: return edge_en & fall;
      DET_BOTH: return edge_en & (rise | fall);
      default:  return 1'b0;
    endcase
  endfunction

  // Write merge: only writable bits take the new value.
  function automatic logic [CTL_W-1:0] ctl_merge(input logic [CTL_W-1:0] old_v,
                                                 input logic [CTL_W-1:0] new_v);
    return (old_v & ~CTL_WMASK) | (new_v & CTL_WMASK);
  endfunction
endpackage

// File: rtl/gpio_ctl_reg.sv
module gpio_ctl_reg
  import gpio_cell_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr,
  input  logic [CTL_W-1:0] wdata,
  output logic [CTL_W-1:0] ctl
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  ctl <= CTL_RESET;
    else if (wr) ctl <= ctl_merge(ctl, wdata);
  end
endmodule

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pad_in,
  output logic lvl,
  output logic prev
);
  localparam int CHAIN = STAGES + 1;
  logic [CHAIN-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= '0;
    else        chain <= {chain[CHAIN-2:0], pad_in};
  end

  assign lvl  = chain[STAGES-1];
  assign prev = chain[STAGES];
endmodule

// File: rtl/gpio_evt_detect.sv
module gpio_evt_detect
  import gpio_cell_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] mode,
  input  logic       edge_en,
  input  logic       lvl,
  input  logic       prev,
  output logic       evt
);
  logic rise_seen, fall_seen, edge_mode;
  assign rise_seen = lvl & ~prev;
  assign fall_seen = ~lvl & prev;
  assign edge_mode = mode[2] & (mode[1:0] != 2'b00);
  assign evt       = det_event(mode, edge_en, lvl, prev);

  assert_edge_gate_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_mode && !edge_en) |-> !evt);
  assert_no_edge_no_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_mode && !rise_seen && !fall_seen) |-> !evt);
  assert_off_codes_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == DET_OFF || mode == 3'b010 || mode == 3'b011) |-> !evt);
  assert_high_level_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == DET_HIGH) |-> (evt == lvl));
endmodule

// File: rtl/gpio_pad_drive.sv
module gpio_pad_drive #(
  parameter int NFUNC  = 3,
  parameter int FSEL_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [FSEL_W-1:0] fsel,
  input  logic              gpio_lvl,
  input  logic              gpio_drv,
  input  logic              od_en,
  input  logic [NFUNC-1:0]  alt_out,
  input  logic [NFUNC-1:0]  alt_oe,
  output logic              pad_out,
  output logic              pad_oe
);
  logic src_out, src_oe;

  always_comb begin
    src_out = gpio_lvl;
    src_oe  = gpio_drv;
    for (int k = 0; k < NFUNC; k++) begin
      if (fsel == FSEL_W'(k + 1)) begin
        src_out = alt_out[k];
        src_oe  = alt_oe[k];
      end
    end
  end

  assign pad_out = od_en ? 1'b0 : src_out;
  assign pad_oe  = od_en ? (src_oe & ~src_out) : src_oe;

  assert_od_never_high_R4: assert property (@(posedge clk) disable iff (!rst_n)
    od_en |-> !pad_out);
  assert_od_release_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (od_en && src_out) |-> !pad_oe);
endmodule

// File: rtl/gpio_pin_cell.sv
module gpio_pin_cell
  import gpio_cell_pkg::*;
#(
  parameter int NFUNC       = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [CTL_W-1:0]  reg_wdata,
  output logic [CTL_W-1:0]  reg_rdata,
  input  logic              pad_in,
  output logic              pad_out,
  output logic              pad_oe,
  output logic              pad_pu,
  output logic              pad_pd,
  input  logic [NFUNC-1:0]  alt_out,
  input  logic [NFUNC-1:0]  alt_oe,
  output logic              evt
);
  localparam int FSEL_W = $clog2(NFUNC + 1);

  logic [CTL_W-1:0] ctl;
  logic             pin_lvl, pin_prev;
  logic [1:0]       pull_pair;

  gpio_ctl_reg u_reg (
    .clk(clk), .rst_n(rst_n), .wr(reg_wr), .wdata(reg_wdata), .ctl(ctl)
  );

  gpio_in_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .pad_in(pad_in), .lvl(pin_lvl), .prev(pin_prev)
  );

  gpio_evt_detect u_det (
    .clk(clk), .rst_n(rst_n),
    .mode(ctl[DET_LSB +: 3]), .edge_en(ctl[EDGE_EN_BIT]),
    .lvl(pin_lvl), .prev(pin_prev), .evt(evt)
  );

  gpio_pad_drive #(.NFUNC(NFUNC), .FSEL_W(FSEL_W)) u_drv (
    .clk(clk), .rst_n(rst_n),
    .fsel(ctl[FSEL_LSB +: FSEL_W]), .gpio_lvl(ctl[LEVEL_BIT]),
    .gpio_drv(ctl[DRV_EN_BIT]), .od_en(ctl[OD_BIT]),
    .alt_out(alt_out), .alt_oe(alt_oe), .pad_out(pad_out), .pad_oe(pad_oe)
  );

  assign pull_pair = pull_decode(ctl[PULL_LSB +: 2]);
  assign pad_pu    = pull_pair[0];
  assign pad_pd    = pull_pair[1];

  always_comb begin
    reg_rdata          = ctl & CTL_WMASK;
    reg_rdata[PIN_BIT] = pin_lvl;
  end

  // Checker state: cycles since reset release, saturating.
  logic [1:0] since_rst;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                since_rst <= '0;
    else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
  end

  assert_pull_exclusive_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !(pad_pu && pad_pd));
  assert_pin_latency_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (since_rst >= 2'd2) |-> (reg_rdata[PIN_BIT] == $past(pad_in, 2)));
  assert_write_lands_R10: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr |=> ((reg_rdata & CTL_WMASK) == ($past(reg_wdata) & CTL_WMASK)));
endmodule

// File: tb/sim_gpio_pin_cell.sv
`timescale 1ns/1ps
module sim_gpio_pin_cell;
  localparam logic [31:0] WMASK  = 32'h0001_37F3; // R6
  localparam logic [31:0] RSTVAL = 32'h0000_0440; // R1

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        pad_in = 1'b0;
  logic        pad_out, pad_oe, pad_pu, pad_pd, evt;
  logic [2:0]  alt_out = '0, alt_oe = '0;

  int n_chk = 0;
  int n_err = 0;

  always #5 clk = ~clk;

  gpio_pin_cell u0 (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe),
    .pad_pu(pad_pu), .pad_pd(pad_pd), .alt_out(alt_out), .alt_oe(alt_oe), .evt(evt)
  );

  // Expected state built from the requirements.
  logic [31:0] m_reg;
  logic        m1, m2, m3;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_reg <= RSTVAL; m1 <= 1'b0; m2 <= 1'b0; m3 <= 1'b0;
    end else begin
      if (reg_wr) m_reg <= (m_reg & ~WMASK) | (reg_wdata & WMASK);
      m1 <= pad_in; m2 <= m1; m3 <= m2;
    end
  end

  function automatic logic want_evt(input logic [31:0] r, input logic now, input logic was);
    logic [2:0] code = r[6:4];
    if (code == 3'b000) return !now;
    if (code == 3'b001) return now;
    if (!r[7])          return 1'b0;
    if (code == 3'b101) return now && !was;
    if (code == 3'b110) return !now && was;
    if (code == 3'b111) return now != was;
    return 1'b0;
  endfunction

  function automatic logic [1:0] want_pad(input logic [31:0] r,
                                          input logic [2:0] ao, input logic [2:0] ae);
    logic lv, en;
    int sel = int'(r[13:12]);
    lv = (sel == 0) ? r[16] : ao[sel-1];
    en = (sel == 0) ? r[9]  : ae[sel-1];
    if (r[8]) return {1'b0, en & ~lv};   // {out, oe}
    return {lv, en};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic check_all();
    logic [1:0] pd;
    string pad_req;
    pd = want_pad(m_reg, alt_out, alt_oe);
    pad_req = (m_reg[13:12] != 0) ? "R5" : (m_reg[8] ? "R4" : "R3");
    chk("R6/R10 rdata", reg_rdata, (m_reg & WMASK) | (32'(m2) << 24));
    chk({pad_req, " pad"}, {30'd0, pad_out, pad_oe}, {30'd0, pd});
    chk("R2 pulls", {30'd0, pad_pd, pad_pu},
        {30'd0, m_reg[1:0] == 2'b10, m_reg[1:0] == 2'b01});
    chk((m_reg[6:5] == 2'b00) ? "R7 evt" : "R8/R9 evt",
        {31'd0, evt}, {31'd0, want_evt(m_reg, m2, m3)});
  endtask

  task automatic cyc(input logic wr, input logic [31:0] wd, input logic pin);
    @(negedge clk);
    check_all();
    reg_wr = wr; reg_wdata = wd; pad_in = pin;
  endtask

  logic done = 1'b0;
  initial begin
    #(100000 * 10);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    pad_in = 1'b1;
    #23;
    // R1: reset state
    chk("R1 reset word", reg_rdata, RSTVAL);
    chk("R1 reset pads", {28'd0, pad_oe, pad_pu, pad_pd, evt}, 32'd0);
    rst_n = 1'b1;
    cyc(1'b0, '0, 1'b0);
    cyc(1'b0, '0, 1'b0);
    cyc(1'b0, '0, 1'b0);
    // R6: writes to bit 24 and unassigned bits ignored
    cyc(1'b1, 32'hFFFF_FFFF, 1'b0);
    cyc(1'b0, '0, 1'b0);
    chk("R6 masked write", reg_rdata, WMASK);
    chk("R2 pull 11 none", {30'd0, pad_pu, pad_pd}, 32'd0);
    // R8: rising edge pulse timing, edge enable set (code 101 + bit 7)
    cyc(1'b1, 32'h0000_00D0, 1'b0);
    cyc(1'b0, '0, 1'b0);
    cyc(1'b0, '0, 1'b1);
    @(negedge clk); chk("R8 no pulse yet", {31'd0, evt}, 32'd0);
    @(negedge clk); chk("R8 pulse", {31'd0, evt}, 32'd1);
    chk("R6 pin visible", {31'd0, reg_rdata[24]}, 32'd1);
    @(negedge clk); chk("R8 pulse one cycle", {31'd0, evt}, 32'd0);
    // R8: same code without edge enable
    cyc(1'b1, 32'h0000_0050, 1'b0);
    repeat (4) begin
      @(negedge clk); chk("R8 gated edge", {31'd0, evt}, 32'd0);
    end
    // R7: low level with bit 7 set
    cyc(1'b1, 32'h0000_0080, 1'b0);
    repeat (3) cyc(1'b0, '0, 1'b0);
    chk("R7 low level", {31'd0, evt}, 32'd1);
    // Random mix
    for (int i = 0; i < 4000; i++) begin
      logic w, p;
      w = ($urandom_range(0, 3) == 0);
      p = (i % 200 < 100) ? $urandom_range(0, 1) : ((i % 16) < 8);
      alt_out = 3'($urandom);
      alt_oe  = 3'($urandom);
      cyc(w, $urandom, p);
    end
    cyc(1'b0, '0, 1'b0);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule